// File: doc/BRIEF.md
# Two-Cycle Switching-Noise Chunk Encoder and Decoder

This block carries 4-bit data chunks across a narrow 3-lane channel in two clock slots per chunk. Its aim is to limit simultaneous switching noise and inductive coupling on the lanes. In the first slot the three low bits of the chunk are placed on the lanes. Before they are driven, a transition counter compares them with the values the lanes last held. If two or more lanes would toggle together, the three bits are sent inverted. In the second slot, one lane carries the top data bit, one lane carries a grounded shield, and the last lane carries the inversion marker.

The inversion marker is signalled by releasing the lane (output enable low) rather than by driving it high, so that no current flows on that lane when the chunk is inverted. When the chunk is not inverted, the marker lane is driven low. Each lane has its own value and output-enable signal. A released lane keeps, for switching purposes, the last value that was driven on it. A matching decoder watches the same lanes, rebuilds the chunk and presents it for one cycle.

Chunks enter through a valid/ready pair that accepts at most one chunk every two clocks. When no chunk is in flight, the lanes are released.

Top module: `ssn_chunk_link`

## Requirements
- R1: Synchronous active-low reset gives the following state: in_ready high, all lane_oe bits 0, out_valid 0, and a remembered lane state of 000.
- R2: A chunk is taken on a clock edge where in_valid and in_ready are both high. in_ready is low in the slot that drives the first tuple, and high in the second-tuple slot and when idle. A valid offered in the first-tuple slot is not taken.
- R3: The first-tuple slot follows the accepting edge. In that slot all lane_oe bits are 1, and lane i carries chunk bit i (i = 0..2). If two or more of those bits differ from the remembered lane state, all three are inverted instead.
- R4: In the second-tuple slot, lane 0 carries chunk bit 3 and lane 1 is a shield driven 0, both enabled. Lane 2 is driven 0 with enable 1 when the first tuple was not inverted. Lane 2 has enable 0 when the first tuple was inverted.
- R5: After every slot, the remembered state of each enabled lane takes the driven value. A released lane keeps its previous remembered value.
- R6: When no chunk is in flight, all lane_oe bits are 0 and the remembered state is unchanged.
- R7: The decoder raises out_valid for exactly one cycle, the cycle after each second-tuple slot. In that cycle out_data equals the chunk that was sent. A released lane 2 in the second slot tells the decoder to undo the inversion.
- R8: In every first-tuple slot, fewer than two lanes change relative to the remembered state, unless the non-inverted form of the tuple would also have changed two or more lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Chunk offered |
| in_data | input | LANES+1 (4) | Chunk value |
| in_ready | output | 1 | Chunk can be taken this cycle |
| lane_val | output | LANES (3) | Value driven on each lane |
| lane_oe | output | LANES (3) | Per-lane output enable; 0 means released (high impedance) |
| out_valid | output | 1 | Rebuilt chunk present |
| out_data | output | LANES+1 (4) | Rebuilt chunk |

## Verification
The bench targets a chunk that follows an inverted chunk. In that case the released marker lane must still count as its older value. A design that cleared or updated that lane would pick the wrong polarity for tuples such as 110 after an inverted 011.

The bench also offers data during the first-tuple slot. A design that took it would drop a chunk or lose alignment between the lanes and the decoder.

Back-to-back chunks, long idle gaps and all sixteen values are checked through the round trip. A decoder that ignored the marker, or counted an idle cycle as a first tuple, would return a wrong or extra chunk.

// File: rtl/ssn_link_pkg.sv
// Package: shared slot encoding for the two-slot chunk encoder.
// Assumes: one chunk occupies exactly two consecutive slots on the lanes.
package ssn_link_pkg;

    // Which slot the encoder is driving in the current cycle.
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_FIRST  = 2'd1,
        SLOT_SECOND = 2'd2
    } slot_e;

endpackage

// File: rtl/ssn_toggle_check.sv
// Module: counts how many lanes would change between a candidate tuple and
// the remembered lane state, and flags the tuple when the count reaches the
// threshold.
// Assumes: THRESH is between 1 and LANES.
module ssn_toggle_check #(
    parameter int LANES  = 3,
    parameter int THRESH = 2
) (
    input  logic [LANES-1:0] cand,
    input  logic [LANES-1:0] prev,
    output logic             too_many
);

    localparam int CNT_W = $clog2(LANES + 1);
    localparam logic [CNT_W-1:0] TH_W = CNT_W'(THRESH);

    logic [LANES-1:0] diff;
    logic [CNT_W-1:0] n_toggle;

    // Per-lane change mask.
    assign diff = cand ^ prev;

    // Population count of the change mask.
    always_comb begin
        n_toggle = '0;
        for (int k = 0; k < LANES; k++) begin
            n_toggle = n_toggle + CNT_W'(diff[k]);
        end
    end

    // Flag when too many lanes would switch together.
    assign too_many = (n_toggle >= TH_W);

endmodule

// File: rtl/ssn_tx_encoder.sv
// Module: accepts a chunk and drives it over two slots. In slot one it sends
// the low LANES bits, inverted if that reduces simultaneous toggles. In slot
// two it sends the top bit, a grounded shield, and the marker lane, which is
// released when the chunk was inverted. It also keeps the remembered state
// of each lane.
// Assumes: LANES >= 3; released lanes keep their last driven value for
// switching purposes.
module ssn_tx_encoder
    import ssn_link_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int THRESH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LANES:0]   in_data,
    output logic             in_ready,
    output logic [LANES-1:0] lane_val,
    output logic [LANES-1:0] lane_oe
);

    localparam int MARK = LANES - 1;

    slot_e            slot_q;
    logic [LANES:0]   chunk_q;
    logic             inv_q;
    logic [LANES-1:0] prev_q;
    logic [LANES-1:0] first_tuple;
    logic             flip_now;
    logic             take;

    assign first_tuple = chunk_q[LANES-1:0];

    ssn_toggle_check #(
        .LANES (LANES),
        .THRESH(THRESH)
    ) u_check (
        .cand    (first_tuple),
        .prev    (prev_q),
        .too_many(flip_now)
    );

    // Ready in every slot except the first tuple of a chunk.
    assign in_ready = (slot_q != SLOT_FIRST);
    assign take     = in_valid && in_ready;

    // Lane drive for the current slot.
    always_comb begin
        lane_val = '0;
        lane_oe  = '0;
        case (slot_q)
            SLOT_FIRST: begin
                lane_oe  = '1;
                lane_val = flip_now ? ~first_tuple : first_tuple;
            end
            SLOT_SECOND: begin
                lane_oe       = '1;
                lane_val[0]   = chunk_q[LANES];
                lane_oe[MARK] = ~inv_q;
            end
            default: begin
                lane_val = '0;
                lane_oe  = '0;
            end
        endcase
    end

    // Slot sequencing, chunk capture and inversion memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= SLOT_IDLE;
            chunk_q <= '0;
            inv_q   <= 1'b0;
        end else begin
            case (slot_q)
                SLOT_IDLE: begin
                    if (take) begin
                        chunk_q <= in_data;
                        slot_q  <= SLOT_FIRST;
                    end
                end
                SLOT_FIRST: begin
                    inv_q  <= flip_now;
                    slot_q <= SLOT_SECOND;
                end
                SLOT_SECOND: begin
                    if (take) begin
                        chunk_q <= in_data;
                        slot_q  <= SLOT_FIRST;
                    end else begin
                        slot_q <= SLOT_IDLE;
                    end
                end
                default: slot_q <= SLOT_IDLE;
            endcase
        end
    end

    // Remembered lane state follows driven lanes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_oe[k]) begin
                    prev_q[k] <= lane_val[k];
                end
            end
        end
    end

    AST_SSN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_FIRST) |->
            (($countones(lane_val ^ prev_q) < THRESH) ||
             ($countones(~lane_val ^ prev_q) >= THRESH))); // R8

    AST_MARK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_SECOND) |->
            (lane_oe[MARK] == ($past(lane_val) == chunk_q[LANES-1:0]))); // R4

    AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe[MARK] |=> (prev_q[MARK] == $past(prev_q[MARK]))); // R5

endmodule

// File: rtl/ssn_rx_decoder.sv
// Module: rebuilds chunks from the lanes. The first all-enabled cycle after
// idle is taken as tuple one and the next cycle as tuple two. A released
// marker lane in tuple two means tuple one was inverted.
// Assumes: the encoder releases every lane when idle, so framing stays
// aligned after reset.
module ssn_rx_decoder #(
    parameter int LANES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_val,
    input  logic [LANES-1:0] lane_oe,
    output logic             out_valid,
    output logic [LANES:0]   out_data
);

    localparam int MARK = LANES - 1;

    logic             have_first_q;
    logic [LANES-1:0] first_q;

    // Two-step framing and chunk reconstruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_first_q <= 1'b0;
            first_q      <= '0;
            out_valid    <= 1'b0;
            out_data     <= '0;
        end else begin
            out_valid <= 1'b0;
            if (!have_first_q) begin
                if (&lane_oe) begin
                    first_q      <= lane_val;
                    have_first_q <= 1'b1;
                end
            end else begin
                have_first_q <= 1'b0;
                out_valid    <= 1'b1;
                out_data     <= {lane_val[0], lane_oe[MARK] ? first_q : ~first_q};
            end
        end
    end

    AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R7

endmodule

// File: rtl/ssn_chunk_link.sv
// Module: top of the two-slot chunk link; connects the encoder to the lanes
// and the decoder to the same lanes.
// Assumes: the lanes are point to point, with no delay between encoder and
// decoder.
module ssn_chunk_link #(
    parameter int LANES      = 3,
    parameter int SSN_THRESH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LANES:0]   in_data,
    output logic             in_ready,
    output logic [LANES-1:0] lane_val,
    output logic [LANES-1:0] lane_oe,
    output logic             out_valid,
    output logic [LANES:0]   out_data
);

    ssn_tx_encoder #(
        .LANES (LANES),
        .THRESH(SSN_THRESH)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_data (in_data),
        .in_ready(in_ready),
        .lane_val(lane_val),
        .lane_oe (lane_oe)
    );

    ssn_rx_decoder #(
        .LANES(LANES)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_val (lane_val),
        .lane_oe  (lane_oe),
        .out_valid(out_valid),
        .out_data (out_data)
    );

endmodule

// File: tb/ssn_chunk_link_bench.sv
`timescale 1ns/1ps
module ssn_chunk_link_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_data = 4'h0;
    logic       in_ready;
    logic [2:0] lane_val;
    logic [2:0] lane_oe;
    logic       out_valid;
    logic [3:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    int       m_phase = 0;
    logic [3:0] m_chunk = 4'h0;
    logic       m_inv = 1'b0;
    logic [2:0] m_prev = 3'b000;
    logic       m_pend = 1'b0;
    logic [3:0] m_pend_data = 4'h0;
    logic [2:0] m_drive = 3'b000;

    always #4 clk = ~clk;

    ssn_chunk_link u_ssn_chunk_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .lane_val (lane_val),
        .lane_oe  (lane_oe),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    function automatic int pop3(input logic [2:0] v);
        int n = 0;
        for (int k = 0; k < 3; k++) n += int'(v[k]);
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: compare outputs with the model, then apply new inputs and
    // advance the model to the state after the coming edge.
    task automatic step(input bit v, input logic [3:0] d);
        int c1;
        int c2;
        @(negedge clk);
        check(in_ready == (m_phase != 1), "R2", "in_ready", int'(in_ready), int'(m_phase != 1));
        case (m_phase)
            0: check(lane_oe == 3'b000, "R6", "idle lane_oe", int'(lane_oe), 0);
            1: begin
                m_inv   = (pop3(m_chunk[2:0] ^ m_prev) >= 2);
                m_drive = m_inv ? ~m_chunk[2:0] : m_chunk[2:0];
                check(lane_oe == 3'b111, "R3", "first lane_oe", int'(lane_oe), 7);
                check(lane_val == m_drive, "R3", "first lane_val", int'(lane_val), int'(m_drive));
                c1 = pop3(lane_val ^ m_prev);
                c2 = pop3(~lane_val ^ m_prev);
                check((c1 < 2) || (c2 >= 2), "R8", "first toggles", c1, 1);
            end
            default: begin
                check(lane_oe == {~m_inv, 2'b11}, "R4", "second lane_oe",
                      int'(lane_oe), int'({~m_inv, 2'b11}));
                check(lane_val[1:0] == {1'b0, m_chunk[3]}, "R4", "second lane_val",
                      int'(lane_val[1:0]), int'({1'b0, m_chunk[3]}));
                if (!m_inv)
                    check(lane_val[2] == 1'b0, "R4", "marker low", int'(lane_val[2]), 0);
            end
        endcase
        check(out_valid == m_pend, "R7", "out_valid", int'(out_valid), int'(m_pend));
        if (m_pend)
            check(out_data == m_pend_data, "R7", "round trip", int'(out_data), int'(m_pend_data));

        in_valid = v;
        in_data  = d;
        m_pend   = 1'b0;
        case (m_phase)
            0: if (v) begin m_chunk = d; m_phase = 1; end
            1: begin m_prev = m_drive; m_phase = 2; end
            default: begin
                m_prev[0] = m_chunk[3];
                m_prev[1] = 1'b0;
                if (!m_inv) m_prev[2] = 1'b0; // R5: released lane keeps value
                m_pend      = 1'b1;
                m_pend_data = m_chunk;
                if (v) begin m_chunk = d; m_phase = 1; end
                else m_phase = 0;
            end
        endcase
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
        check(lane_oe == 3'b000, "R1", "reset lane_oe", int'(lane_oe), 0);
        check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;

        // R1/R3: first chunk 0x3 against reset state 000 must be inverted.
        step(1'b1, 4'h3);
        step(1'b0, 4'h0);
        step(1'b0, 4'h0);
        // R5: after released marker, 0x6 (low 110) must stay uninverted.
        step(1'b1, 4'h6);
        step(1'b1, 4'hF); // R2: offered in first slot, must be ignored
        step(1'b0, 4'h0);
        step(1'b0, 4'h0);
        step(1'b0, 4'h0);
        // Back-to-back sweep of all values.
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 4'(i));
            step(1'b1, 4'(15 - i));
        end
        for (int i = 0; i < 4; i++) step(1'b0, 4'h0);
        // Random traffic with gaps.
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 3) != 0, 4'($urandom));
        end
        for (int i = 0; i < 4; i++) step(1'b0, 4'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule